// File: doc/BRIEF.md
# Display RAM Host Data Path with Holding Register

This block sits between a host port and the byte-organised display memory of a 65-line by 132-column dot-matrix panel controller. The 65 lines are stored as nine pages of eight lines each. The ninth page carries only its lowest line. Within a page, each column is one byte. A stored 1 lights a pixel and a stored 0 leaves it dark. The host sets a page and a column, then streams bytes in or out. After each transfer the column moves on by one, and it stops at the last column.

Every transfer passes through a single holding register. A written byte is parked in the holder and copied into memory one cycle later. A read works the other way. The host receives what the holder already contains, while the memory byte at the current column is fetched into the holder for the next read. As a result, the first read after an address set returns old data, and the byte for the new address arrives on the second read.

The host must leave at least one idle cycle after each data write or data read pulse. Address sets may follow one another back to back.

Top module: `dram_hold_path`

## Requirements
- R1: After reset the holder, page and column are zero. `rd_byte` reads 0x00, and the first read after reset returns 0x00.
- R2: A write pulse raises `ram_we` in the following cycle, with `ram_wdata` equal to the written byte (after the R9 mask) and `ram_col`/`ram_page` equal to the current address.
- R3: After each write the column advances by one, so consecutive writes land in columns N, N+1, N+2.
- R4: A read pulse updates `rd_byte` at that clock edge to the holder contents as they were before the read. The value holds until the next read.
- R5: The first read after an address set returns the stale holder value: the last byte written, or the last byte fetched. The second read returns the byte stored at the set address.
- R6: After each read the column advances by one, so streaming reads return consecutive columns, one read late.
- R7: The column saturates at 131. A transfer at column 131 leaves it at 131, and the page never changes on its own.
- R8: A column set above 131 loads 131. A page set above 8 loads 8. Both values are taken from `addr_val`.
- R9: Page 8 stores only bit 0. Bits 7:1 written to page 8 reach memory as 0. The holder itself keeps the full byte.
- R10: `ram_we` is asserted only in the cycle after a write pulse. A read never changes memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_set | input | 1 | Load page from `addr_val` (clamped to 8) |
| col_set | input | 1 | Load column from `addr_val` (clamped to 131) |
| addr_val | input | 8 | Address value for page or column set |
| wr_pulse | input | 1 | One-cycle host data write |
| rd_pulse | input | 1 | One-cycle host data read |
| wr_byte | input | 8 | Host write data |
| ram_page | output | 4 | Current memory page |
| ram_col | output | 8 | Current memory column |
| ram_we | output | 1 | Memory write strobe |
| ram_wdata | output | 8 | Memory write byte |
| rd_byte | output | 8 | Byte returned to the host by the last read |

## Verification
A wrong column counter shows up on the very next write, through `ram_col`. It also shows up one read late as a shifted byte stream. A corrupted holder appears on the next read, in the stale value that follows an address set. A missing or misplaced fetch shows after two reads, when the second read should carry the byte written earlier at that address. The page 8 mask and the saturation limit show in `ram_wdata` and `ram_col` in the same cycle as the write-back.

// File: rtl/dram_pkg.sv
package dram_pkg;
  localparam int BYTE_W    = 8;
  localparam int LINES     = 65;
  localparam int COLS      = 132;
  localparam int PAGES     = (LINES + BYTE_W - 1) / BYTE_W;
  localparam int LAST_PAGE = PAGES - 1;
  localparam int LAST_BITS = LINES - BYTE_W * LAST_PAGE;
  localparam int COL_W     = $clog2(COLS);
  localparam int PAGE_W    = $clog2(PAGES);
  localparam int DEPTH     = PAGES * COLS;
  localparam int IDX_W     = $clog2(DEPTH);

  typedef enum logic [1:0] {SQ_IDLE, SQ_WBACK, SQ_FETCH} seq_t;

  function automatic logic [COL_W-1:0] col_step(input logic [COL_W-1:0] c);
    return (c >= COL_W'(COLS - 1)) ? COL_W'(COLS - 1) : c + 1'b1;
  endfunction

  function automatic logic [COL_W-1:0] col_clamp(input logic [BYTE_W-1:0] v);
    return (int'(v) > COLS - 1) ? COL_W'(COLS - 1) : COL_W'(v);
  endfunction

  function automatic logic [PAGE_W-1:0] page_clamp(input logic [BYTE_W-1:0] v);
    return (int'(v) > LAST_PAGE) ? PAGE_W'(LAST_PAGE) : PAGE_W'(v);
  endfunction

  function automatic logic [BYTE_W-1:0] byte_mask(input logic [PAGE_W-1:0] p);
    return (int'(p) == LAST_PAGE) ? BYTE_W'((1 << LAST_BITS) - 1) : {BYTE_W{1'b1}};
  endfunction

  function automatic logic [IDX_W-1:0] cell_idx(input logic [PAGE_W-1:0] p,
                                                input logic [COL_W-1:0] c);
    return IDX_W'(p) * IDX_W'(COLS) + IDX_W'(c);
  endfunction
endpackage

// File: rtl/dram_addr_ctr.sv
module dram_addr_ctr
  import dram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_set,
  input  logic              col_set,
  input  logic [BYTE_W-1:0] addr_val,
  input  logic              advance,
  output logic [PAGE_W-1:0] page,
  output logic [COL_W-1:0]  col
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page <= '0;
      col  <= '0;
    end else begin
      if (page_set) page <= page_clamp(addr_val);
      if (col_set) col <= col_clamp(addr_val);
      else if (advance) col <= col_step(col);
    end
  end

  // R7
  col_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) <= COLS - 1);
  // R8
  page_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(page) <= LAST_PAGE);
  // R3
  col_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !col_set && int'(col) < COLS - 1) |=> (col == $past(col) + 1'b1));
endmodule

// File: rtl/dram_holder_seq.sv
module dram_holder_seq
  import dram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic              rd_pulse,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] ram_dout,
  input  logic [PAGE_W-1:0] page,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              advance,
  output logic [BYTE_W-1:0] rd_byte
);
  seq_t              state;
  logic [BYTE_W-1:0] holder;
  logic              wback_evt;
  logic              fetch_evt;

  assign wback_evt = (state == SQ_WBACK);
  assign fetch_evt = (state == SQ_FETCH);
  assign advance   = wback_evt | fetch_evt;
  assign ram_we    = wback_evt;
  assign ram_wdata = holder & byte_mask(page);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      holder  <= '0;
      rd_byte <= '0;
    end else begin
      state <= SQ_IDLE;
      if (fetch_evt) holder <= ram_dout;
      if (wr_pulse) begin
        holder <= wr_byte;
        state  <= SQ_WBACK;
      end else if (rd_pulse) begin
        rd_byte <= holder;
        state   <= SQ_FETCH;
      end
    end
  end

  // R10
  we_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> ram_we);
  // R10
  no_we_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !wr_pulse) |=> !ram_we);
  // R4
  rd_returns_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !wr_pulse) |=> (rd_byte == $past(holder)));
  // R4
  rd_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pulse |=> $stable(rd_byte));
endmodule

// File: rtl/dram_array.sv
module dram_array
  import dram_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [PAGE_W-1:0] page,
  input  logic [COL_W-1:0]  col,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] dout
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx = cell_idx(page, col);

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    dout <= mem[idx];
  end

  // R9
  last_page_masked_chk: assert property (@(posedge clk)
    (we && int'(page) == LAST_PAGE) |-> ((wdata & ~byte_mask(page)) == '0));
endmodule

// File: rtl/dram_hold_path.sv
module dram_hold_path
  import dram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_set,
  input  logic              col_set,
  input  logic [BYTE_W-1:0] addr_val,
  input  logic              wr_pulse,
  input  logic              rd_pulse,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [PAGE_W-1:0] ram_page,
  output logic [COL_W-1:0]  ram_col,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic [BYTE_W-1:0] rd_byte
);
  logic              advance;
  logic [BYTE_W-1:0] ram_dout;

  dram_addr_ctr u_addr (
    .clk(clk), .rst_n(rst_n), .page_set(page_set), .col_set(col_set),
    .addr_val(addr_val), .advance(advance), .page(ram_page), .col(ram_col)
  );

  dram_holder_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
    .wr_byte(wr_byte), .ram_dout(ram_dout), .page(ram_page),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .advance(advance), .rd_byte(rd_byte)
  );

  dram_array u_mem (
    .clk(clk), .we(ram_we), .page(ram_page), .col(ram_col),
    .wdata(ram_wdata), .dout(ram_dout)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (ram_col == '0 && ram_page == '0 && rd_byte == '0 && !ram_we));
endmodule

// File: tb/sim_dram_hold_path.sv
module sim_dram_hold_path;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       page_set = 1'b0, col_set = 1'b0, wr_pulse = 1'b0, rd_pulse = 1'b0;
  logic [7:0] addr_val = '0, wr_byte = '0;
  logic [3:0] ram_page;
  logic [7:0] ram_col, ram_wdata, rd_byte;
  logic       ram_we;
  int         errors = 0;
  int         checks = 0;

  always #(PERIOD/2) clk = ~clk;

  dram_hold_path u0 (
    .clk(clk), .rst_n(rst_n), .page_set(page_set), .col_set(col_set),
    .addr_val(addr_val), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
    .wr_byte(wr_byte), .ram_page(ram_page), .ram_col(ram_col),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .rd_byte(rd_byte)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_page(input logic [7:0] v);
    @(negedge clk); page_set = 1'b1; addr_val = v;
    @(negedge clk); page_set = 1'b0;
  endtask

  task automatic set_col(input logic [7:0] v);
    @(negedge clk); col_set = 1'b1; addr_val = v;
    @(negedge clk); col_set = 1'b0;
  endtask

  // one write; checks the write-back cycle
  task automatic do_wr(input logic [7:0] b, input int exp_page, input int exp_col,
                       input int exp_data, input string tag);
    @(negedge clk); wr_pulse = 1'b1; wr_byte = b;
    @(negedge clk); wr_pulse = 1'b0;
    chk({tag, " R2 ram_we"}, int'(ram_we), 1);
    chk({tag, " R3 ram_col"}, int'(ram_col), exp_col);
    chk({tag, " R2 ram_page"}, int'(ram_page), exp_page);
    chk({tag, " R2 ram_wdata"}, int'(ram_wdata), exp_data);
    @(negedge clk);
  endtask

  // one read; checks the returned byte and that no write occurs
  task automatic do_rd(input int exp, input string tag);
    @(negedge clk); rd_pulse = 1'b1;
    @(negedge clk); rd_pulse = 1'b0;
    chk({tag, " R4 rd_byte"}, int'(rd_byte), exp);
    chk({tag, " R10 no write"}, int'(ram_we), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rd_byte after reset", int'(rd_byte), 0);
    chk("R1 column after reset", int'(ram_col), 0);
    chk("R1 page after reset", int'(ram_page), 0);
    chk("R10 idle no write", int'(ram_we), 0);
    do_rd(0, "R1 first read");
  endtask

  task automatic t_stream();
    set_page(8'd2); set_col(8'd10);
    do_wr(8'hA1, 2, 10, 'hA1, "R3 w0");
    do_wr(8'hA2, 2, 11, 'hA2, "R3 w1");
    do_wr(8'hA3, 2, 12, 'hA3, "R3 w2");
    set_col(8'd10);
    do_rd('hA3, "R5 dummy");
    do_rd('hA1, "R5 second R6 c10");
    do_rd('hA2, "R6 c11");
    do_rd('hA3, "R6 c12");
    chk("R6 column after reads", int'(ram_col), 14);
  endtask

  task automatic t_saturate();
    set_page(8'd1); set_col(8'd130);
    do_wr(8'h11, 1, 130, 'h11, "R7 w130");
    do_wr(8'h22, 1, 131, 'h22, "R7 w131");
    do_wr(8'h33, 1, 131, 'h33, "R7 stuck");
    chk("R7 column held", int'(ram_col), 131);
    chk("R7 page held", int'(ram_page), 1);
    set_col(8'd130);
    do_rd('h33, "R5 dummy sat");
    do_rd('h11, "R7 c130");
    do_rd('h33, "R7 c131");
    do_rd('h33, "R7 c131 again");
  endtask

  task automatic t_clamp();
    set_page(8'd3); set_col(8'd200);
    chk("R8 column clamp", int'(ram_col), 131);
    do_wr(8'h5A, 3, 131, 'h5A, "R8 col");
    set_page(8'd15); set_col(8'd5);
    chk("R8 page clamp", int'(ram_page), 8);
    do_wr(8'hFF, 8, 5, 'h01, "R9 mask");
    set_col(8'd5);
    do_rd('hFF, "R9 holder full");
    do_rd('h01, "R9 stored bit0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_saturate();
    t_clamp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule